// File: doc/BRIEF.md
# Floppy Controller Execution-Phase Data FIFO

This block is the byte buffer between the host bus and the disk data path of a floppy disk controller. A producer port pushes bytes and a consumer port pops them. Which side is the host depends on the transfer direction: for a disk read the disk side produces and the host consumes, and for a disk write the host produces and the disk side consumes. When a configure write has enabled the buffer and the controller is in the execution phase, the full 16 entries are in use. In any other phase, or while the buffer is disabled, the block holds a single byte and behaves as a one-byte data register with a request threshold of one.

A pacer drives the host request line, which serves as a DMA or interrupt request. It asserts the line when the threshold condition is met: enough bytes to read, or enough free room to write. It then keeps a burst count equal to the threshold. In burst mode the request stays high until that many host transfers have completed. In non-burst mode the request drops for a fixed gap after each host transfer. The gap is 350 ns converted to core clock cycles and rounded up. The pacer then resumes if bytes of the burst remain.

Enable, lock and threshold state survive a soft reset in the ways the requirements list. Sticky overrun and underrun flags report a push into a full buffer and a pop from an empty one.

Top module: `fdc_xfer_fifo`

## Requirements
- R1: With the buffer enabled and `exec_phase` high, 16 bytes are accepted. A push while 16 are held is dropped, leaving `fill_lvl` at 16.
- R2: With `exec_phase` low or the buffer disabled, at most one byte is accepted and the request threshold is one. A second push is dropped and sets `overrun`.
- R3: A cycle with `cfg_we` high loads `fifo_on` from `cfg_en` and the threshold code from `cfg_thr`. The threshold is the code plus one, so code 0 means 1 and code 15 means 16.
- R4: After hardware reset (`rst_n` low), `fifo_on` is 0, lock is clear, the threshold code is 0, the buffer is empty, `xfer_req` is 0, and both flags are 0.
- R5: A cycle with `sw_rst` high empties the buffer, clears both flags, returns the pacer to idle, and keeps the threshold. `fifo_on` stays set only if the lock (written through `lock_we`/`lock_val`) is set. Otherwise it is cleared.
- R6: With `dir_read`=1, the pacer starts a burst in the cycle after `fill_lvl` reaches the threshold. `xfer_req` is high from the clock edge after that condition is seen.
- R7: With `dir_read`=0, the pacer starts a burst when free space (capacity minus `fill_lvl`) is at least the threshold.
- R8: In burst mode (`burst_mode`=1), once raised, `xfer_req` stays high until the threshold number of host transfers have completed. It is low right after the last of them.
- R9: In non-burst mode, `xfer_req` is low for exactly ceil(350 ns × clock MHz / 1000) cycles after each host transfer, which is 9 cycles at the default 24 MHz. It is then high again if the burst is unfinished, or idle if the burst is done.
- R10: `overrun` and `underrun` are sticky until a reset. `underrun` is set by a pop while the buffer is empty.
- R11: Bytes leave the consumer port (`cons_data`, first-word fall-through) in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| sw_rst | input | 1 | Soft reset pulse, synchronous |
| cfg_we | input | 1 | Configure write strobe |
| cfg_en | input | 1 | Enable value loaded by configure |
| cfg_thr | input | 4 | Threshold code (threshold = code + 1) |
| lock_we | input | 1 | Lock write strobe |
| lock_val | input | 1 | Lock value |
| burst_mode | input | 1 | 1 = burst pacing, 0 = gap after each byte |
| exec_phase | input | 1 | Controller is in the execution phase |
| dir_read | input | 1 | 1 = disk-to-host, 0 = host-to-disk |
| prod_push | input | 1 | Producer push strobe |
| prod_data | input | 8 | Producer byte |
| cons_pop | input | 1 | Consumer pop strobe |
| cons_data | output | 8 | Oldest held byte |
| xfer_req | output | 1 | DMA / interrupt request to the host |
| fifo_on | output | 1 | Buffer enable state |
| fill_lvl | output | 5 | Bytes held |
| overrun | output | 1 | Sticky: push into a full buffer |
| underrun | output | 1 | Sticky: pop from an empty buffer |

## Verification
The bench goes after the gap length in non-burst mode. A design that counted one cycle too few or too many would reassert the request early or late, and the bench samples every cycle of the gap. It checks that a burst ends on exactly the threshold-th host transfer, so a pacer that reevaluates the fill level mid-burst would drop or extend the request. It covers the write direction at a threshold of 16, where a design comparing fill level instead of free space would never request. It checks the soft reset both with and without the lock, and the one-byte bypass outside the execution phase, where a design that kept full depth would miss the overrun.

// File: rtl/fdc_fifo_pkg.sv
package fdc_fifo_pkg;
   typedef enum logic [1:0] {
      PS_IDLE   = 2'd0,
      PS_ACTIVE = 2'd1,
      PS_GAP    = 2'd2
   } pace_t;

   // Nanoseconds to clock cycles, rounded up.
   function automatic int ns_to_cycles(input int ns, input int mhz);
      return (ns * mhz + 999) / 1000;
   endfunction
endpackage

// File: rtl/fdc_fifo_cfg.sv
module fdc_fifo_cfg #(
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sw_rst,
   input  logic          cfg_we,
   input  logic          cfg_en,
   input  logic [AW-1:0] cfg_thr,
   input  logic          lock_we,
   input  logic          lock_val,
   output logic          en_q,
   output logic          lock_q,
   output logic [AW-1:0] thr_code_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= 1'b0;
         lock_q     <= 1'b0;
         thr_code_q <= '0;
      end else begin
         if (sw_rst && !lock_q) en_q <= 1'b0;
         if (cfg_we) begin
            en_q       <= cfg_en;
            thr_code_q <= cfg_thr;
         end
         if (lock_we) lock_q <= lock_val;
      end
   end
endmodule

// File: rtl/fdc_fifo_store.sv
module fdc_fifo_store #(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   parameter int AW    = $clog2(DEPTH),
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic [CW-1:0] cap,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic [CW-1:0] level,
   output logic          push_ok,
   output logic          pop_ok,
   output logic          ovr_q,
   output logic          und_q
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;

   assign push_ok = push && (level < cap);
   assign pop_ok  = pop && (level != '0);
   assign rdata   = mem[rptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
         ovr_q <= 1'b0;
         und_q <= 1'b0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
         ovr_q <= 1'b0;
         und_q <= 1'b0;
      end else begin
         if (push_ok) wptr <= wptr + 1'b1;
         if (pop_ok)  rptr <= rptr + 1'b1;
         level <= level + CW'(push_ok) - CW'(pop_ok);
         if (push && !push_ok) ovr_q <= 1'b1;
         if (pop && !pop_ok)   und_q <= 1'b1;
      end
   end
endmodule

// File: rtl/fdc_fifo_pacer.sv
module fdc_fifo_pacer
   import fdc_fifo_pkg::*;
#(
   parameter int CW      = 5,
   parameter int GAP_CYC = 9,
   parameter int GW      = $clog2(GAP_CYC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          cond,
   input  logic          host_acc,
   input  logic          burst,
   input  logic [CW-1:0] thr_eff,
   output logic          req
);
   pace_t         st;
   logic [CW-1:0] rem;
   logic [GW-1:0] gcnt;

   assign req = (st == PS_ACTIVE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= PS_IDLE;
         rem  <= '0;
         gcnt <= '0;
      end else if (flush) begin
         st   <= PS_IDLE;
         rem  <= '0;
         gcnt <= '0;
      end else begin
         unique case (st)
            PS_IDLE: if (cond) begin
               st  <= PS_ACTIVE;
               rem <= thr_eff;
            end
            PS_ACTIVE: if (host_acc) begin
               rem <= rem - 1'b1;
               if (burst) begin
                  if (rem == CW'(1)) st <= PS_IDLE;
               end else begin
                  st   <= PS_GAP;
                  gcnt <= GW'(GAP_CYC);
               end
            end
            PS_GAP: begin
               gcnt <= gcnt - 1'b1;
               if (gcnt == GW'(1)) st <= (rem == '0) ? PS_IDLE : PS_ACTIVE;
            end
            default: st <= PS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fdc_xfer_fifo.sv
module fdc_xfer_fifo
   import fdc_fifo_pkg::*;
#(
   parameter int  DW      = 8,
   parameter int  DEPTH   = 16,
   parameter int  CLK_MHZ = 24,
   parameter int  GAP_NS  = 350,
   localparam int AW      = $clog2(DEPTH),
   localparam int CW      = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sw_rst,
   input  logic          cfg_we,
   input  logic          cfg_en,
   input  logic [AW-1:0] cfg_thr,
   input  logic          lock_we,
   input  logic          lock_val,
   input  logic          burst_mode,
   input  logic          exec_phase,
   input  logic          dir_read,
   input  logic          prod_push,
   input  logic [DW-1:0] prod_data,
   input  logic          cons_pop,
   output logic [DW-1:0] cons_data,
   output logic          xfer_req,
   output logic          fifo_on,
   output logic [CW-1:0] fill_lvl,
   output logic          overrun,
   output logic          underrun
);
   localparam int GAP_CYC = ns_to_cycles(GAP_NS, CLK_MHZ);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (GAP_CYC < 1) begin : g_bad_gap
      $error("gap must span at least one cycle");
   end

   logic          lock_q;
   logic [AW-1:0] thr_code;
   logic          bypass;
   logic [CW-1:0] cap, thr_eff, free_lvl;
   logic          push_ok, pop_ok, host_acc, cond;

   fdc_fifo_cfg #(.AW(AW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
      .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_thr(cfg_thr),
      .lock_we(lock_we), .lock_val(lock_val),
      .en_q(fifo_on), .lock_q(lock_q), .thr_code_q(thr_code)
   );

   assign bypass   = !(exec_phase && fifo_on);
   assign cap      = bypass ? CW'(1) : CW'(DEPTH);
   assign thr_eff  = bypass ? CW'(1) : (CW'(thr_code) + CW'(1));
   assign free_lvl = (fill_lvl >= cap) ? '0 : (cap - fill_lvl);
   assign cond     = dir_read ? (fill_lvl >= thr_eff) : (free_lvl >= thr_eff);
   assign host_acc = dir_read ? pop_ok : push_ok;

   fdc_fifo_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(sw_rst), .cap(cap),
      .push(prod_push), .wdata(prod_data), .pop(cons_pop), .rdata(cons_data),
      .level(fill_lvl), .push_ok(push_ok), .pop_ok(pop_ok),
      .ovr_q(overrun), .und_q(underrun)
   );

   fdc_fifo_pacer #(.CW(CW), .GAP_CYC(GAP_CYC)) u_pacer (
      .clk(clk), .rst_n(rst_n), .flush(sw_rst), .cond(cond),
      .host_acc(host_acc), .burst(burst_mode), .thr_eff(thr_eff),
      .req(xfer_req)
   );
endmodule

// File: rtl/fdc_xfer_fifo_chk.sv
module fdc_xfer_fifo_chk #(
   parameter int DEPTH = 16,
   parameter int CW    = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sw_rst,
   input logic          cfg_we,
   input logic          exec_phase,
   input logic          fifo_on,
   input logic          lock_q,
   input logic          burst_mode,
   input logic          xfer_req,
   input logic          host_acc,
   input logic [CW-1:0] fill_lvl,
   input logic          overrun,
   input logic          underrun
);
   // R1
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_lvl <= CW'(DEPTH));

   // R2
   bypass_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(exec_phase && fifo_on) && fill_lvl != '0 && !sw_rst)
      |=> (fill_lvl <= $past(fill_lvl)));

   // R5
   lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_rst && lock_q && fifo_on && !cfg_we) |=> fifo_on);

   // R5
   unlock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_rst && !lock_q && !cfg_we) |=> !fifo_on);

   // R10
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !sw_rst) |=> overrun);

   // R10
   und_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && !sw_rst) |=> underrun);

   // R9
   gap_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && host_acc && !burst_mode) |=> !xfer_req);
endmodule

bind fdc_xfer_fifo fdc_xfer_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cfg_we(cfg_we),
   .exec_phase(exec_phase), .fifo_on(fifo_on), .lock_q(lock_q),
   .burst_mode(burst_mode), .xfer_req(xfer_req), .host_acc(host_acc),
   .fill_lvl(fill_lvl), .overrun(overrun), .underrun(underrun)
);

// File: tb/sim_fdc_xfer_fifo.sv
`timescale 1ns/1ps
module sim_fdc_xfer_fifo;
   localparam int DEPTH = 16;
   localparam int GAP   = (350 * 24 + 999) / 1000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0, sw_rst = 1'b0, cfg_we = 1'b0, cfg_en = 1'b0;
   logic [3:0] cfg_thr = '0;
   logic       lock_we = 1'b0, lock_val = 1'b0, burst_mode = 1'b1;
   logic       exec_phase = 1'b0, dir_read = 1'b1, prod_push = 1'b0, cons_pop = 1'b0;
   logic [7:0] prod_data = '0;
   logic [7:0] cons_data;
   logic       xfer_req, fifo_on, overrun, underrun;
   logic [4:0] fill_lvl;

   int checks = 0, errs = 0;
   logic [7:0] m [DEPTH];
   int head = 0, cnt = 0;
   logic m_ovr = 1'b0, m_und = 1'b0;

   always #2 clk = ~clk;

   fdc_xfer_fifo u0 (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cfg_we(cfg_we), .cfg_en(cfg_en),
      .cfg_thr(cfg_thr), .lock_we(lock_we), .lock_val(lock_val),
      .burst_mode(burst_mode), .exec_phase(exec_phase), .dir_read(dir_read),
      .prod_push(prod_push), .prod_data(prod_data), .cons_pop(cons_pop),
      .cons_data(cons_data), .xfer_req(xfer_req), .fifo_on(fifo_on),
      .fill_lvl(fill_lvl), .overrun(overrun), .underrun(underrun)
   );

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   // One clock; strobes set before the call, cleared after the edge.
   task automatic cyc();
      @(posedge clk); #1;
      sw_rst = 0; cfg_we = 0; lock_we = 0; prod_push = 0; cons_pop = 0;
   endtask

   task automatic push(input logic [7:0] d);
      prod_push = 1; prod_data = d; cyc();
   endtask

   task automatic pop();
      cons_pop = 1; cyc();
   endtask

   function automatic logic [7:0] pat(input int i);
      return 8'(i * 37 + 5);
   endfunction

   initial begin
      #(200000 * 4);
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h1F0D));
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R4 reset state
      chk("R4 fifo_on", fifo_on, 0);
      chk("R4 level", fill_lvl, 0);
      chk("R4 req", xfer_req, 0);
      chk("R4 flags", {overrun, underrun}, 0);

      // R2 bypass: one-byte register, threshold one
      push(8'hA1);
      chk("R2 level one", fill_lvl, 1);
      cyc();
      chk("R2 req threshold one", xfer_req, 1);
      push(8'hB2);
      chk("R2 second push dropped", fill_lvl, 1);
      chk("R2 overrun", overrun, 1);
      chk("R11 bypass data", cons_data, 8'hA1);
      pop();
      chk("R2 req cleared after byte", xfer_req, 0);
      pop();
      chk("R10 underrun", underrun, 1);
      cyc();
      chk("R10 overrun sticky", overrun, 1);
      sw_rst = 1; cyc();
      chk("R5 flags cleared", {overrun, underrun}, 0);

      // R3 configure, R6 read request, R8 burst
      cfg_we = 1; cfg_en = 1; cfg_thr = 4'd3; cyc();
      chk("R3 enabled", fifo_on, 1);
      exec_phase = 1; burst_mode = 1; dir_read = 1;
      for (int i = 0; i < 3; i++) push(pat(i));
      cyc();
      chk("R6 below threshold", xfer_req, 0);
      push(pat(3));
      chk("R6 req not yet", xfer_req, 0);
      cyc();
      chk("R6 req at threshold", xfer_req, 1);
      for (int i = 0; i < 3; i++) begin
         chk("R11 order", cons_data, pat(i));
         pop();
         chk("R8 req held in burst", xfer_req, 1);
      end
      pop();
      chk("R8 req drops after burst", xfer_req, 0);
      cyc();
      chk("R8 stays idle when empty", xfer_req, 0);

      // R9 non-burst gap
      cfg_we = 1; cfg_en = 1; cfg_thr = 4'd1; burst_mode = 0; cyc();
      push(8'h11); push(8'h22); cyc();
      chk("R9 req raised", xfer_req, 1);
      pop();
      for (int i = 0; i < GAP; i++) begin
         chk($sformatf("R9 gap cycle %0d", i), xfer_req, 0);
         cyc();
      end
      chk("R9 req resumes after gap", xfer_req, 1);
      pop();
      repeat (GAP + 3) cyc();
      chk("R9 idle after last byte", xfer_req, 0);

      // R7 write direction, threshold 16
      burst_mode = 1; cfg_we = 1; cfg_en = 1; cfg_thr = 4'd15; cyc();
      dir_read = 0; cyc();
      chk("R7 req on empty", xfer_req, 1);
      for (int i = 0; i < 15; i++) push(pat(i));
      chk("R7 burst held", xfer_req, 1);
      push(pat(15));
      chk("R7 burst end", xfer_req, 0);
      chk("R1 full level", fill_lvl, 16);
      push(8'hEE);
      chk("R1 17th dropped", fill_lvl, 16);
      chk("R1 overrun", overrun, 1);
      pop(); cyc();
      chk("R7 free one no req", xfer_req, 0);
      for (int i = 0; i < 15; i++) pop();
      chk("R7 not yet", xfer_req, 0);
      cyc();
      chk("R7 req at free 16", xfer_req, 1);
      dir_read = 1;

      // R5 soft reset with and without lock
      lock_we = 1; lock_val = 0; cyc();
      sw_rst = 1; cyc();
      chk("R5 unlocked drops enable", fifo_on, 0);
      cfg_we = 1; cfg_en = 1; cfg_thr = 4'd15; lock_we = 1; lock_val = 1; cyc();
      push(8'h55);
      sw_rst = 1; cyc();
      chk("R5 locked keeps enable", fifo_on, 1);
      chk("R5 flushed", fill_lvl, 0);

      // R1 R10 R11 random traffic against a model
      head = 0; cnt = 0; m_ovr = 0; m_und = 0;
      for (int it = 0; it < 600; it++) begin
         logic p, q;
         p = ($urandom % 100) < 55;
         q = ($urandom % 100) < 45;
         chk("R1 level model", fill_lvl, cnt);
         if (q && cnt > 0) chk("R11 data model", cons_data, m[head]);
         prod_push = p; prod_data = 8'($urandom); cons_pop = q;
         if (p) begin
            if (cnt < DEPTH) m[(head + cnt) % DEPTH] = prod_data;
            else m_ovr = 1;
         end
         if (q) begin
            if (cnt > 0) head = (head + 1) % DEPTH;
            else m_und = 1;
         end
         cnt = cnt + ((p && cnt < DEPTH) ? 1 : 0) - ((q && cnt > 0) ? 1 : 0);
         cyc();
         chk("R10 flags model", {overrun, underrun}, {m_ovr, m_und});
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule